// File: doc/BRIEF.md
# Stepped Data ROM Read Port

This block lets a host processor stream bytes out of a large read-only data store through a small window of byte-wide registers. The host loads a 24-bit base pointer, a 16-bit offset and a 16-bit step, and then reads a data register over and over. Each such read returns one byte from a one-byte prefetch buffer and moves a pointer forward, so the next byte is already waiting. A 7-bit mode register sets how the fetch address is formed and how the pointers move.

The mode register chooses between a unit step and the programmed step, and whether the step is sign-extended. It chooses whether the step moves the base or the offset, and whether the fetch address adds the offset (zero- or sign-extended). It can also make an offset-byte write, or a read of a dedicated trigger register, add the offset to the base. Whenever a pointer or the mode changes, the buffer is refilled from the ROM. The ROM port has one clock of latency. For the two cycles of a refill the block raises `busy`, and it ignores host strobes during those cycles.

Top module: `romstep_port`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `busy` and `rom_en` are low and the data register reads 0.
- R2: Register indices are: 0 data, 1/2/3 base bytes low/mid/high, 4/5 offset low/high, 6/7 step low/high, 8 mode, 9 trigger. Indices 1 to 8 read back the last value accepted. Mode stores only bits 6:0, so its bit 7 reads 0. Index 9 and unused indices read 0.
- R3: A refill is started by a write to the base high byte or to mode. A refill raises `busy` for exactly the two cycles after the accepting edge. `rom_en` is high in the first of those two cycles only. After the refill, the data register holds the ROM byte at the fetch address.
- R4: The fetch address is the base alone when mode bit 1 is 0. When mode bit 1 is 1, it is base plus offset, modulo 2^24. The offset is sign-extended when mode bit 3 is 1 and zero-extended otherwise.
- R5: A read of index 0 returns the buffered byte and then advances. The step is the step register when mode bit 0 is 1, and 1 otherwise. The step is sign-extended when mode bit 2 is 1. With mode bit 4 set the step is added to the offset (mod 2^16); otherwise it is added to the base (mod 2^24). A refill follows.
- R6: Mode bits 6:5 select an automatic advance: base += offset (extended per mode bit 3), then a refill. The advance happens on a write to offset low for 01, on a write to offset high for 10, and on a read of index 9 for 11. A read of index 9 returns 0, and has no effect for any other field value.
- R7: A write to offset high also refills when mode bit 1 is 1. If that write also triggers an advance, the buffer ends up holding the byte at the advanced address. A write to offset high with mode bit 1 clear and no advance does not refill.
- R8: While `busy` is high, host writes and reads change no register and start no advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register index |
| host_wdata | input | 8 | Write byte |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_rdata | output | 8 | Read byte for `host_addr`, combinational |
| busy | output | 1 | Refill in progress; strobes are ignored |
| rom_en | output | 1 | ROM read request |
| rom_addr | output | 24 | ROM byte address |
| rom_data | input | 8 | ROM byte, valid one clock after `rom_en` |

## Verification
A write to offset high can cause both the offset-enabled refill and the field-10 automatic advance in the same edge. The bench sets mode to 0x42 and writes offset high, then checks that `rom_addr` in the issue cycle and the buffered byte both come from the advanced base, not from the old base. A second collision is a host strobe landing while a refill is still in flight. The bench drives a step write and then a data read into the two busy cycles, and judges them by reading back every register and the buffer afterwards against the behavioural model.

// File: rtl/romstep_pkg.sv
package romstep_pkg;

    // Host register indices; the map is part of the block's contract.
    typedef enum logic [3:0] {
        RI_DATA   = 4'd0,
        RI_BASE_L = 4'd1,
        RI_BASE_M = 4'd2,
        RI_BASE_H = 4'd3,
        RI_OFF_L  = 4'd4,
        RI_OFF_H  = 4'd5,
        RI_STEP_L = 4'd6,
        RI_STEP_H = 4'd7,
        RI_MODE   = 4'd8,
        RI_TRIG   = 4'd9
    } reg_idx_e;

    localparam int MODE_W = 7;

    // Mode bit positions
    localparam int M_CUSTOM_STEP = 0;
    localparam int M_USE_OFF     = 1;
    localparam int M_STEP_SIGNED = 2;
    localparam int M_OFF_SIGNED  = 3;
    localparam int M_STEP_TO_OFF = 4;
    localparam int M_AUTO_LO     = 5;
    localparam int M_AUTO_HI     = 6;

    // Automatic advance selection (mode bits 6:5)
    typedef enum logic [1:0] {
        AUTO_NONE   = 2'd0,
        AUTO_OFF_LO = 2'd1,
        AUTO_OFF_HI = 2'd2,
        AUTO_TRIG   = 2'd3
    } auto_e;

    // Prefetch sequencer states
    typedef enum logic [1:0] {
        F_IDLE    = 2'd0,
        F_ISSUE   = 2'd1,
        F_CAPTURE = 2'd2
    } fetch_st_e;

endpackage

// File: rtl/romstep_ext.sv
// Widens a value to a larger width by sign or zero extension.
// Assumes OUT_W > IN_W. Purely combinational.
module romstep_ext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 24
) (
    input  logic [IN_W-1:0]  val,
    input  logic             sign,
    output logic [OUT_W-1:0] ext
);
    localparam int PAD_W = OUT_W - IN_W;

    // Replicate the top bit only when sign extension is selected.
    assign ext = {{PAD_W{sign & val[IN_W-1]}}, val};
endmodule

// File: rtl/romstep_regs.sv
// Register file and pointer-update rules.
// Holds base, offset, step and mode. Applies host writes, data-read
// advances and automatic base advances, and pulses refill_req in any
// cycle whose update needs a new prefetch. Assumes busy stays high
// for a whole refill; no strobe is accepted while busy is high.
module romstep_regs
    import romstep_pkg::*;
#(
    parameter int BASE_W = 24,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              busy,
    output logic [BASE_W-1:0] base_q,
    output logic [OFF_W-1:0]  off_q,
    output logic [OFF_W-1:0]  step_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              refill_req
);
    localparam int BASE_BYTES = BASE_W / DATA_W;
    localparam int OFF_BYTES  = OFF_W / DATA_W;

    logic              wr_ok, rd_ok;
    auto_e             auto_sel;
    logic [OFF_W-1:0]  off_wr, step_src;
    logic [BASE_W-1:0] off_adv, step_adv;
    logic [BASE_W-1:0] base_n;
    logic [OFF_W-1:0]  off_n, step_n;
    logic [MODE_W-1:0] mode_n;

    assign wr_ok    = host_wr && !busy;
    assign rd_ok    = host_rd && !host_wr && !busy;
    assign auto_sel = auto_e'(mode_q[M_AUTO_HI:M_AUTO_LO]);

    // Offset value after any offset-byte write accepted this cycle.
    always_comb begin
        off_wr = off_q;
        if (wr_ok) begin
            for (int k = 0; k < OFF_BYTES; k++) begin
                if (host_addr == ADDR_W'(int'(RI_OFF_L) + k))
                    off_wr[k*DATA_W +: DATA_W] = host_wdata;
            end
        end
    end

    // Unit or programmed step.
    assign step_src = mode_q[M_CUSTOM_STEP] ? step_q : OFF_W'(1);

    romstep_ext #(.IN_W(OFF_W), .OUT_W(BASE_W)) u_off_ext (
        .val (off_wr),
        .sign(mode_q[M_OFF_SIGNED]),
        .ext (off_adv)
    );

    romstep_ext #(.IN_W(OFF_W), .OUT_W(BASE_W)) u_step_ext (
        .val (step_src),
        .sign(mode_q[M_STEP_SIGNED]),
        .ext (step_adv)
    );

    // Next-state rules for all pointer registers and the refill request.
    always_comb begin
        base_n     = base_q;
        off_n      = off_wr;
        step_n     = step_q;
        mode_n     = mode_q;
        refill_req = 1'b0;
        if (wr_ok) begin
            for (int k = 0; k < BASE_BYTES; k++) begin
                if (host_addr == ADDR_W'(int'(RI_BASE_L) + k))
                    base_n[k*DATA_W +: DATA_W] = host_wdata;
            end
            if (host_addr == ADDR_W'(int'(RI_BASE_L) + BASE_BYTES - 1))
                refill_req = 1'b1;
            for (int k = 0; k < OFF_BYTES; k++) begin
                if (host_addr == ADDR_W'(int'(RI_STEP_L) + k))
                    step_n[k*DATA_W +: DATA_W] = host_wdata;
            end
            if (host_addr == ADDR_W'(RI_MODE)) begin
                mode_n     = host_wdata[MODE_W-1:0];
                refill_req = 1'b1;
            end
            if (host_addr == ADDR_W'(RI_OFF_L) && auto_sel == AUTO_OFF_LO) begin
                base_n     = base_q + off_adv;
                refill_req = 1'b1;
            end
            if (host_addr == ADDR_W'(RI_OFF_H)) begin
                if (mode_q[M_USE_OFF])
                    refill_req = 1'b1;
                if (auto_sel == AUTO_OFF_HI) begin
                    base_n     = base_q + off_adv;
                    refill_req = 1'b1;
                end
            end
        end else if (rd_ok) begin
            if (host_addr == ADDR_W'(RI_DATA)) begin
                if (mode_q[M_STEP_TO_OFF])
                    off_n = off_q + step_src;
                else
                    base_n = base_q + step_adv;
                refill_req = 1'b1;
            end
            if (host_addr == ADDR_W'(RI_TRIG) && auto_sel == AUTO_TRIG) begin
                base_n     = base_q + off_adv;
                refill_req = 1'b1;
            end
        end
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
            step_q <= '0;
            mode_q <= '0;
        end else begin
            base_q <= base_n;
            off_q  <= off_n;
            step_q <= step_n;
            mode_q <= mode_n;
        end
    end

    // R8: a refill in flight freezes every register
    p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_q) && $stable(off_q) && $stable(step_q) && $stable(mode_q)));

    // R2: without strobes the registers hold their values
    p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd) |=> ($stable(base_q) && $stable(off_q) && $stable(step_q) && $stable(mode_q)));
endmodule

// File: rtl/romstep_fetch.sv
// Prefetch sequencer and one-byte buffer.
// On refill_req it issues one ROM read at fetch_addr, then captures
// the returned byte into the buffer on the next edge. Assumes the ROM
// returns data exactly one clock after rom_en. Assumes refill_req is
// only raised while idle.
module romstep_fetch
    import romstep_pkg::*;
#(
    parameter int BASE_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refill_req,
    input  logic [BASE_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic              rom_en,
    output logic [BASE_W-1:0] rom_addr,
    output logic [DATA_W-1:0] pf_q,
    output logic              busy
);
    fetch_st_e st_q;

    // Sequencer: idle -> issue -> capture -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= F_IDLE;
        end else begin
            unique case (st_q)
                F_IDLE:    if (refill_req) st_q <= F_ISSUE;
                F_ISSUE:   st_q <= F_CAPTURE;
                F_CAPTURE: st_q <= F_IDLE;
                default:   st_q <= F_IDLE;
            endcase
        end
    end

    // Buffer capture of the ROM byte that returns in the capture state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pf_q <= '0;
        else if (st_q == F_CAPTURE)
            pf_q <= rom_data;
    end

    assign rom_en   = (st_q == F_ISSUE);
    assign rom_addr = fetch_addr;
    assign busy     = (st_q != F_IDLE);

    // R3: each refill issues a single ROM read
    p_rom_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |=> !rom_en);
endmodule

// File: rtl/romstep_port.sv
// Stepped data ROM read port, top level.
// Wires the register file to the prefetch sequencer. Forms the fetch
// address and drives the host read mux. Host reads are combinational
// on host_addr; strobes are single-cycle and ignored while busy.
module romstep_port
    import romstep_pkg::*;
#(
    parameter int BASE_W = 24,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              rom_en,
    output logic [BASE_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data
);
    localparam int BASE_BYTES = BASE_W / DATA_W;
    localparam int OFF_BYTES  = OFF_W / DATA_W;

    logic [BASE_W-1:0] base_q, off_fx, fetch_addr;
    logic [OFF_W-1:0]  off_q, step_q;
    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] pf_q;
    logic              refill_req;

    romstep_regs #(
        .BASE_W(BASE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .busy      (busy),
        .base_q    (base_q),
        .off_q     (off_q),
        .step_q    (step_q),
        .mode_q    (mode_q),
        .refill_req(refill_req)
    );

    romstep_ext #(.IN_W(OFF_W), .OUT_W(BASE_W)) u_fetch_ext (
        .val (off_q),
        .sign(mode_q[M_OFF_SIGNED]),
        .ext (off_fx)
    );

    // Fetch address: base, optionally plus the extended offset.
    assign fetch_addr = base_q + (mode_q[M_USE_OFF] ? off_fx : '0);

    romstep_fetch #(.BASE_W(BASE_W), .DATA_W(DATA_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .refill_req(refill_req),
        .fetch_addr(fetch_addr),
        .rom_data  (rom_data),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .pf_q      (pf_q),
        .busy      (busy)
    );

    // Host read mux; trigger and unused indices read zero.
    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(RI_DATA))
            host_rdata = pf_q;
        for (int k = 0; k < BASE_BYTES; k++) begin
            if (host_addr == ADDR_W'(int'(RI_BASE_L) + k))
                host_rdata = base_q[k*DATA_W +: DATA_W];
        end
        for (int k = 0; k < OFF_BYTES; k++) begin
            if (host_addr == ADDR_W'(int'(RI_OFF_L) + k))
                host_rdata = off_q[k*DATA_W +: DATA_W];
            if (host_addr == ADDR_W'(int'(RI_STEP_L) + k))
                host_rdata = step_q[k*DATA_W +: DATA_W];
        end
        if (host_addr == ADDR_W'(RI_MODE))
            host_rdata = DATA_W'(mode_q);
    end

    // R3: a refill request issues the ROM read on the next cycle
    p_refill_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |=> rom_en);

    // R3: an accepted mode write starts a refill
    p_mode_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !busy && host_addr == ADDR_W'(RI_MODE)) |=> busy);

    // R5: an accepted data read starts a refill
    p_data_read_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !busy && host_addr == ADDR_W'(RI_DATA)) |=> busy);
endmodule

// File: tb/romstep_port_tb.sv
module romstep_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        busy, rom_en;
    logic [23:0] rom_addr;
    logic [7:0]  rom_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Behavioural model state
    logic [23:0] m_base;
    logic [15:0] m_off, m_step;
    logic [6:0]  m_mode;
    logic [7:0]  m_buf;

    always #10 clk = ~clk;

    romstep_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata), .busy(busy),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data)
    );

    function automatic logic [7:0] romf(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
    endfunction

    // ROM with one clock of read latency
    always @(posedge clk) if (rom_en) rom_data <= romf(rom_addr);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] ext16(logic [15:0] v, logic s);
        return (s && v[15]) ? {8'hFF, v} : {8'h00, v};
    endfunction

    function automatic logic [23:0] m_fetch();
        return m_mode[1] ? m_base + ext16(m_off, m_mode[3]) : m_base;
    endfunction

    function automatic logic [7:0] m_rd(int idx);
        case (idx)
            0: return m_buf;
            1: return m_base[7:0];
            2: return m_base[15:8];
            3: return m_base[23:16];
            4: return m_off[7:0];
            5: return m_off[15:8];
            6: return m_step[7:0];
            7: return m_step[15:8];
            8: return {1'b0, m_mode};
            default: return 8'h00;
        endcase
    endfunction

    // Expect refill timing, address and buffer load (R3)
    task automatic expect_refill(string req, bit exp);
        if (exp) begin
            chk({req, " busy c1"}, busy, 1);
            chk({req, " rom_en c1"}, rom_en, 1);
            chk({req, " rom_addr"}, rom_addr, m_fetch());
            @(negedge clk);
            chk({req, " busy c2"}, busy, 1);
            chk({req, " rom_en c2"}, rom_en, 0);
            @(negedge clk);
            chk({req, " busy end"}, busy, 0);
            m_buf = romf(m_fetch());
        end else begin
            chk({req, " no refill"}, busy, 0);
        end
    endtask

    task automatic wr(string req, int idx, logic [7:0] v);
        bit r = 0;
        @(negedge clk);
        host_addr = 4'(idx); host_wdata = v; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
        case (idx)
            1: m_base[7:0] = v;
            2: m_base[15:8] = v;
            3: begin m_base[23:16] = v; r = 1; end
            4: begin
                m_off[7:0] = v;
                if (m_mode[6:5] == 2'b01) begin m_base = m_base + ext16(m_off, m_mode[3]); r = 1; end
            end
            5: begin
                m_off[15:8] = v;
                r = m_mode[1];
                if (m_mode[6:5] == 2'b10) begin m_base = m_base + ext16(m_off, m_mode[3]); r = 1; end
            end
            6: m_step[7:0] = v;
            7: m_step[15:8] = v;
            8: begin m_mode = v[6:0]; r = 1; end
            default: ;
        endcase
        expect_refill(req, r);
    endtask

    task automatic rd(string req, int idx);
        bit r = 0;
        logic [15:0] st;
        @(negedge clk);
        host_addr = 4'(idx); host_rd = 1;
        #2 chk({req, " read value"}, host_rdata, m_rd(idx));
        @(negedge clk);
        host_rd = 0;
        if (idx == 0) begin
            st = m_mode[0] ? m_step : 16'd1;
            if (m_mode[4]) m_off = m_off + st;
            else m_base = m_base + ext16(st, m_mode[2]);
            r = 1;
        end else if (idx == 9 && m_mode[6:5] == 2'b11) begin
            m_base = m_base + ext16(m_off, m_mode[3]);
            r = 1;
        end
        expect_refill(req, r);
    endtask

    task automatic compare_all(string req);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            host_addr = 4'(i);
            #2 chk($sformatf("%s reg%0d", req, i), host_rdata, m_rd(i));
        end
    endtask

    task automatic set_base(string req, logic [23:0] b);
        wr(req, 1, b[7:0]);
        wr(req, 2, b[15:8]);
        wr(req, 3, b[23:16]);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_base = 0; m_off = 0; m_step = 0; m_mode = 0; m_buf = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 rom_en", rom_en, 0);
        compare_all("R1");

        // R2 readback and R3 base-high refill
        set_base("R3 base", 24'h123456);
        wr("R2 off lo", 4, 8'hF0);
        wr("R2 off hi", 5, 8'h00);
        wr("R2 step lo", 6, 8'h03);
        wr("R2 step hi", 7, 8'h00);
        compare_all("R2");
        @(negedge clk); host_addr = 4'd15; #2 chk("R2 unused", host_rdata, 0);

        // R2/R3/R4 mode bit7 dropped, offset addressing
        wr("R4 mode 82", 8, 8'h82);
        chk("R2 mode bit7", m_mode, 7'h02);
        compare_all("R4");

        // R5 unit step on base
        rd("R5 unit", 0);
        chk("R5 base+1", m_base, 24'h123457);
        compare_all("R5 unit");

        // R5 signed custom step, base wrap
        wr("R5 mode 05", 8, 8'h05);
        wr("R5 step lo", 6, 8'hFD);
        wr("R5 step hi", 7, 8'hFF);
        set_base("R5 base", 24'h000001);
        rd("R5 neg1", 0);
        rd("R5 neg2", 0);
        chk("R5 wrap", m_base, 24'hFFFFFB);
        compare_all("R5 signed");

        // R5 step to offset, 16-bit wrap, unsigned step
        wr("R5 mode 13", 8, 8'h13);
        rd("R5 off1", 0);
        rd("R5 off2", 0);
        compare_all("R5 offset");

        // R6 field 01: offset low write advances base, signed offset
        set_base("R6 base", 24'h400000);
        wr("R6 off hi", 5, 8'hFF);
        wr("R6 mode 2A", 8, 8'h2A);
        wr("R6 off lo", 4, 8'h80);
        chk("R6 lo adv", m_base, 24'h3FFF80);
        compare_all("R6 lo");

        // R6 field 10: offset high write advances base (unsigned)
        wr("R6 mode 40", 8, 8'h40);
        wr("R6 off hi", 5, 8'h01);
        compare_all("R6 hi");

        // R7 collision: refill and advance in the same write
        wr("R7 mode 42", 8, 8'h42);
        wr("R7 off hi both", 5, 8'h02);
        compare_all("R7 both");

        // R6 field 11: trigger read advances and returns 0
        wr("R6 mode 60", 8, 8'h60);
        rd("R6 trig", 9);
        compare_all("R6 trig");
        wr("R6 mode 00", 8, 8'h00);
        rd("R6 trig idle", 9);
        compare_all("R6 trig idle");

        // R7 offset-high refill with signed offset, and no refill when bit1 clear
        wr("R7 mode 0A", 8, 8'h0A);
        wr("R7 off hi", 5, 8'h90);
        wr("R7 mode 08", 8, 8'h08);
        wr("R7 no refill", 5, 8'h11);
        compare_all("R7");

        // R8 strobes during busy are ignored
        @(negedge clk);
        host_addr = 4'(8); host_wdata = 8'h01; host_wr = 1;
        @(negedge clk);
        host_wr = 0; m_mode = 7'h01;
        chk("R8 busy c1", busy, 1);
        host_addr = 4'(6); host_wdata = 8'hAA; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
        chk("R8 busy c2", busy, 1);
        host_addr = 4'(0); host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        chk("R8 idle", busy, 0);
        m_buf = romf(m_fetch());
        compare_all("R8");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule